// File: doc/BRIEF.md
# Floating-Point Base-2 Logarithm Estimator

This unit accepts one IEEE single-precision operand per cycle and returns a single-precision estimate of its base-2 logarithm. The sign of an ordinary operand is ignored, so the result is an estimate of log2 of its magnitude. Denormal operands are first normalized with a leading-zero count. The biased exponent becomes the integer part of a signed fixed-point value with 23 fraction bits. The fraction is then built one bit at a time. Three conditional steps compare the mantissa against 2^0.5, 2^0.25 and 2^0.125. Each step that hits sets one fraction bit and scales the mantissa down by the matching reciprocal through a 32x32 multiply-high. A final linear term approximates the part that remains.

The signed fixed-point value is converted back to float format through a magnitude, a leading-zero count and a variable shift. Operands with an all-ones exponent and zero operands bypass the datapath and take fixed results. The unit is a two-stage pipeline with a valid strobe and no back-pressure, so a new operand can be issued every cycle.

Top module: `log2_est`

## Requirements
- R1: An operand with exponent field 0xFF and a zero fraction (an infinity) is returned unchanged. An operand with exponent 0xFF and a nonzero fraction (a NaN) is returned with bit 22 forced to 1 and all other bits unchanged.
- R2: An operand whose bits 30:0 are all zero (+0 or -0) yields 0xFF800000.
- R3: For a denormal operand (exponent field 0, fraction nonzero), lz is the leading-zero count of the 32-bit word holding the fraction. The mantissa is shifted left by lz-8 and the starting fixed-point value is (-118-lz)*2^23. For example, 0x00000001 gives 0xC3150000 (-149.0) and 0x00400000 gives 0xC2FE0000 (-127.0).
- R4: For a normal operand, the starting fixed-point value is (exponent-127)*2^23 and the mantissa carries its hidden bit. Bit 31 of the operand has no effect. Exact powers of two give exact integers: 2.0 gives 1.0, 0.5 gives -1.0, 8.0 gives 3.0, 2^127 gives 127.0, and -2.0 gives 1.0.
- R5: Three reduction steps run in a fixed order. In each step, a mantissa at or above the step's threshold (0xB504F3, then 0x9837F0, then 0x8B95C2) ORs fixed-point bit 22, 21 or 20 respectively into the value. The mantissa is then replaced by the upper 32 bits of its product with 0xB504F334, 0xD744FCCB or 0xEAC0C6E8. No step ever increases the mantissa.
- R6: After the steps, if the mantissa exceeds 0x800000, the upper 32 bits of ((mantissa-0x800000)<<1) x 0xB0C7CD3A are added to the fixed-point value.
- R7: A nonzero fixed-point value is renormalized as follows. The sign is bit 31 of the value. The magnitude's leading-zero count lz gives d = 8-lz. The magnitude is shifted right by d (or left by -d). The result is sign<<31 + (d+126)<<23 + the shifted magnitude, and it is negative exactly when the fixed-point value is.
- R8: A fixed-point value of zero, for example from the operand 1.0 (0x3F800000), yields +0 (0x00000000).
- R9: A result appears on out_data with out_valid high exactly two rising edges after the edge that accepts in_valid. Back-to-back operands give back-to-back results. When out_valid is low, out_data holds its last value.
- R10: While rst is high at a rising edge, out_valid and out_data are cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, two edges after the operand |
| out_data | output | 32 | Single-precision log2 estimate |

## Verification
Every result is due two rising edges after its operand is accepted. The first edge loads the stage that unpacks and reduces the operand. The second edge loads the renormalized output register. The bench drives an operand on a falling edge and samples out_valid and out_data on the second falling edge after that. In burst runs, it samples each result in the same half-cycle in which the operand two slots later is driven. One further falling edge confirms that out_valid has dropped and that out_data has held its value.

// File: rtl/log2e_pkg.sv
package log2e_pkg;

    localparam logic [31:0] ONE_MANT = 32'h0080_0000;
    localparam logic [31:0] LIN_COEF = 32'hB0C7_CD3A;
    localparam logic [31:0] NEG_INF  = 32'hFF80_0000;
    localparam logic [31:0] QNAN_BIT = 32'h0040_0000;
    localparam int          MAX_STEPS = 3;

    typedef struct packed {
        logic        special;
        logic [31:0] spec_val;
        logic [31:0] fixed;
    } stage1_t;

    function automatic logic [31:0] step_thresh(input int k);
        case (k)
            0:       return 32'h00B5_04F3;
            1:       return 32'h0098_37F0;
            default: return 32'h008B_95C2;
        endcase
    endfunction

    function automatic logic [31:0] step_mult(input int k);
        case (k)
            0:       return 32'hB504_F334;
            1:       return 32'hD744_FCCB;
            default: return 32'hEAC0_C6E8;
        endcase
    endfunction

    function automatic logic [31:0] mul_hi(input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        p = {32'd0, a} * {32'd0, b};
        return p[63:32];
    endfunction

    function automatic logic [5:0] clz32(input logic [31:0] v);
        logic [5:0] n;
        logic       seen;
        n    = 6'd0;
        seen = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) seen = 1'b1;
            if (!seen) n = n + 6'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/log2e_unpack.sv
module log2e_unpack
    import log2e_pkg::*;
(
    input  logic [31:0] x,
    output logic        special,
    output logic [31:0] spec_val,
    output logic [31:0] norm_mant,
    output logic [31:0] fixed_init
);
    logic [7:0]  e;
    logic [22:0] f;
    logic [5:0]  lz;

    always_comb begin
        e          = x[30:23];
        f          = x[22:0];
        lz         = clz32({9'd0, f});
        special    = 1'b0;
        spec_val   = 32'd0;
        norm_mant  = {8'd0, 1'b1, f};
        fixed_init = ({24'd0, e} - 32'd127) << 23;
        if (e == 8'hFF) begin
            special  = 1'b1;
            spec_val = (f != 23'd0) ? (x | QNAN_BIT) : x;
        end else if (e == 8'd0) begin
            if (f == 23'd0) begin
                special  = 1'b1;
                spec_val = NEG_INF;
            end
            // denormal: bring the leading one up to bit 23
            norm_mant  = {9'd0, f} << (lz - 6'd8);
            fixed_init = (32'd0 - (32'd118 + {26'd0, lz})) << 23;
        end
    end
endmodule

// File: rtl/log2e_reduce.sv
module log2e_reduce
    import log2e_pkg::*;
#(
    parameter int STEPS = 3
) (
    input  logic [31:0] mant_in,
    input  logic [31:0] fixed_in,
    output logic [31:0] mant_out,
    output logic [31:0] fixed_out
);
    logic [31:0] m_c [STEPS+1];
    logic [31:0] f_c [STEPS+1];
    logic [31:0] lin;

    assign m_c[0] = mant_in;
    assign f_c[0] = fixed_in;

    for (genvar k = 0; k < STEPS; k++) begin : g_step
        logic hit;
        assign hit        = (m_c[k] >= step_thresh(k));
        assign m_c[k+1]   = hit ? mul_hi(m_c[k], step_mult(k)) : m_c[k];
        assign f_c[k+1]   = hit ? (f_c[k] | (32'h0040_0000 >> k)) : f_c[k];
    end

    always_comb begin
        lin = 32'd0;
        if (m_c[STEPS] > ONE_MANT)
            lin = mul_hi((m_c[STEPS] - ONE_MANT) << 1, LIN_COEF);
    end

    assign mant_out  = m_c[STEPS];
    assign fixed_out = f_c[STEPS] + lin;
endmodule

// File: rtl/log2e_pack.sv
module log2e_pack
    import log2e_pkg::*;
(
    input  logic [31:0] fixed,
    output logic [31:0] res
);
    logic        sign;
    logic [31:0] mag;
    logic [31:0] shifted;
    logic [5:0]  lz;
    logic [7:0]  ebias;

    always_comb begin
        sign    = fixed[31];
        mag     = sign ? (32'd0 - fixed) : fixed;
        lz      = clz32(mag);
        shifted = (lz < 6'd8) ? (mag >> (6'd8 - lz)) : (mag << (lz - 6'd8));
        ebias   = 8'd134 - {2'd0, lz};
        if (fixed == 32'd0)
            res = 32'd0;
        else
            res = {sign, 31'd0} + {1'b0, ebias, 23'd0} + shifted;
    end
endmodule

// File: rtl/log2_est.sv
module log2_est
    import log2e_pkg::*;
#(
    parameter int RED_STEPS = MAX_STEPS
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        out_valid,
    output logic [31:0] out_data
);
    logic        u_special;
    logic [31:0] u_spec_val, u_mant, u_fixed;
    logic [31:0] r_mant, r_fixed;
    logic [31:0] p_res;
    stage1_t     s1;
    logic        v1;

    log2e_unpack u_unpack (
        .x(in_data), .special(u_special), .spec_val(u_spec_val),
        .norm_mant(u_mant), .fixed_init(u_fixed)
    );

    log2e_reduce #(.STEPS(RED_STEPS)) u_reduce (
        .mant_in(u_mant), .fixed_in(u_fixed),
        .mant_out(r_mant), .fixed_out(r_fixed)
    );

    log2e_pack u_pack (.fixed(s1.fixed), .res(p_res));

    always_ff @(posedge clk) begin
        if (rst) begin
            v1        <= 1'b0;
            s1        <= '0;
            out_valid <= 1'b0;
            out_data  <= 32'd0;
        end else begin
            v1        <= in_valid;
            out_valid <= v1;
            if (in_valid)
                s1 <= '{special: u_special, spec_val: u_spec_val, fixed: r_fixed};
            if (v1)
                out_data <= s1.special ? s1.spec_val : p_res;
        end
    end

    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_data[30:23] == 8'hFF && in_data[22:0] != 23'd0
        |=> s1.special && s1.spec_val[22] && s1.spec_val[30:23] == 8'hFF); // R1
    AST_ZERO_NEG_INF: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_data[30:0] == 31'd0
        |=> s1.special && s1.spec_val == NEG_INF); // R2
    AST_DENORM_NEG: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_data[30:23] == 8'd0 && in_data[22:0] != 23'd0
        |=> !s1.special && s1.fixed[31]); // R3
    AST_REDUCE_SHRINK: assert property (@(posedge clk) disable iff (rst)
        in_valid && !u_special |-> r_mant <= u_mant); // R5
    AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (rst)
        v1 && !s1.special && s1.fixed != 32'd0
        |=> out_data[31] == $past(s1.fixed[31])); // R7
    AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (rst)
        v1 && !s1.special && s1.fixed == 32'd0 |=> out_data == 32'd0); // R8
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> v1 |=> out_valid); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !v1 |=> !out_valid && $stable(out_data)); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !out_valid && out_data == 32'd0); // R10
endmodule

// File: tb/log2_est_tb.sv
`timescale 1ns/1ps
module log2_est_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = 32'd0;
    logic        out_valid;
    logic [31:0] out_data;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    log2_est u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    // {operand, expected}
    localparam int NVEC = 15;
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h3F80_0000, 32'h0000_0000},   // R8 1.0
        {32'h4000_0000, 32'h3F80_0000},   // R4 2.0
        {32'h3F00_0000, 32'hBF80_0000},   // R4 0.5
        {32'h4100_0000, 32'h4040_0000},   // R4 8.0
        {32'h3E80_0000, 32'hC000_0000},   // R4 0.25
        {32'h7F00_0000, 32'h42FE_0000},   // R4 2^127
        {32'hC000_0000, 32'h3F80_0000},   // R4 sign ignored
        {32'h0000_0001, 32'hC315_0000},   // R3 smallest denormal
        {32'h0040_0000, 32'hC2FE_0000},   // R3
        {32'h0000_0000, 32'hFF80_0000},   // R2
        {32'h8000_0000, 32'hFF80_0000},   // R2
        {32'h7F80_0000, 32'h7F80_0000},   // R1 +Inf
        {32'hFF80_0000, 32'hFF80_0000},   // R1 -Inf
        {32'h7F80_0001, 32'h7FC0_0001},   // R1 NaN
        {32'hFFA0_0000, 32'hFFE0_0000}    // R1 NaN
    };

    function automatic logic [31:0] mh(input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        p = {32'd0, a} * {32'd0, b};
        return p[63:32];
    endfunction

    function automatic int nlz(input logic [31:0] v);
        int n = 32;
        for (int i = 0; i < 32; i++) if (v[i]) n = 31 - i;
        return n;
    endfunction

    // model written from requirements R1..R8
    function automatic logic [31:0] ref_log2(input logic [31:0] x);
        logic [31:0] m, fx, mag, sh;
        int lz, d;
        if (x[30:23] == 8'hFF) return (x[22:0] != 0) ? (x | 32'h0040_0000) : x;
        if (x[30:0] == 0) return 32'hFF80_0000;
        if (x[30:23] == 0) begin
            m  = {9'd0, x[22:0]};
            lz = nlz(m);
            m  = m << (lz - 8);
            fx = 32'(-118 - lz) << 23;
        end else begin
            m  = {8'd0, 1'b1, x[22:0]};
            fx = (32'(x[30:23]) - 32'd127) << 23;
        end
        if (m >= 32'hB504F3) begin fx |= 32'h400000; m = mh(m, 32'hB504F334); end
        if (m >= 32'h9837F0) begin fx |= 32'h200000; m = mh(m, 32'hD744FCCB); end
        if (m >= 32'h8B95C2) begin fx |= 32'h100000; m = mh(m, 32'hEAC0C6E8); end
        if (m > 32'h800000) fx = fx + mh((m - 32'h800000) << 1, 32'hB0C7CD3A);
        if (fx == 0) return 32'd0;
        mag = fx[31] ? -fx : fx;
        lz  = nlz(mag);
        d   = 8 - lz;
        sh  = (d > 0) ? (mag >> d) : (mag << (-d));
        return {fx[31], 31'd0} + (32'(d + 126) << 23) + sh;
    endfunction

    function automatic string req_of(input logic [31:0] x);
        if (x[30:23] == 8'hFF) return "R1";
        if (x[30:0] == 0) return "R2";
        if (x[30:23] == 0) return "R3";
        if (x == 32'h3F80_0000) return "R8";
        return "R4";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_one(input string req, input logic [31:0] x, input logic [31:0] exp);
        @(negedge clk); in_valid = 1'b1; in_data = x;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R9 valid", {31'd0, out_valid}, 32'd1);
        check(req, out_data, exp);
    endtask

    initial begin
        logic [31:0] seed;
        logic [31:0] ra, rb, rc;
        repeat (3) @(negedge clk);
        check("R10 reset valid", {31'd0, out_valid}, 32'd0);
        check("R10 reset data", out_data, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++)
            run_one(req_of(VEC[i][63:32]), VEC[i][63:32], VEC[i][31:0]);

        // reduction thresholds and linear term (R5, R6) against the model
        run_one("R5 max finite", 32'h7F7F_FFFF, ref_log2(32'h7F7F_FFFF));
        run_one("R5 at sqrt2", 32'h3FB5_04F3, ref_log2(32'h3FB5_04F3));
        run_one("R5 below sqrt2", 32'h3FB5_04F2, ref_log2(32'h3FB5_04F2));
        run_one("R5 at 2^0.25", 32'h3F98_37F0, ref_log2(32'h3F98_37F0));
        run_one("R6 linear only", 32'h3F80_1000, ref_log2(32'h3F80_1000));
        seed = 32'h1234_5678;
        for (int i = 0; i < 300; i++) begin
            seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
            run_one("R6/R7 sweep", seed, ref_log2(seed));
        end

        // R9: idle cycle keeps valid low and data held
        @(negedge clk);
        check("R9 idle valid", {31'd0, out_valid}, 32'd0);
        check("R9 hold", out_data, ref_log2(seed));

        // R9: back-to-back burst
        ra = 32'h4000_0000; rb = 32'h3E80_0000; rc = 32'h0000_0001;
        @(negedge clk); in_valid = 1'b1; in_data = ra;
        @(negedge clk); in_data = rb;
        @(negedge clk);
        check("R9 burst a", out_data, 32'h3F80_0000);
        in_data = rc;
        @(negedge clk);
        check("R9 burst b", out_data, 32'hC000_0000);
        check("R9 burst valid", {31'd0, out_valid}, 32'd1);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 burst c", out_data, 32'hC315_0000);
        @(negedge clk);
        check("R9 burst end", {31'd0, out_valid}, 32'd0);
        check("R9 burst hold", out_data, 32'hC315_0000);

        // R10: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R10 clear valid", {31'd0, out_valid}, 32'd0);
        check("R10 clear data", out_data, 32'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule